// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block collects interrupt requests from peripherals and from software and hands each CPU interface its single most urgent candidate. Interrupt numbers fall into three classes. Numbers 0 to 15 are software interrupts that are raised by a register write. Numbers 16 to 31 are private to each CPU. Numbers 32 and above are shared peripheral lines. Software programs the block over a simple 32-bit word-addressed register bus. Every access carries the index of the CPU that issues it, so the private numbers can be banked per CPU at one shared address.

For each interrupt the block stores an enable bit, a pending bit and an active bit. Each of these states has a set view and a clear view. It also stores an 8-bit priority, a CPU routing byte for shared lines, and an edge-or-level trigger choice. On every cycle an arbiter per CPU scans the candidates that are pending, enabled, not active and routed to that CPU. It picks the lowest priority value and breaks ties by the lower number. The result is registered onto a valid/ID pair per CPU. A global enable bit gates all forwarding.

Top module: `intd_dist`

## Requirements
- R1: Enable, pending and active bits of numbers 0-31 are held separately for each CPU, and a bus access reaches the copy of the CPU given by `bus_cpu`. Numbers 32 and up have one shared copy.
- R2: Word address bits [11:8] select the register group: 1 is enable-set, 2 is enable-clear, 3 is pending-set, 4 is pending-clear, 5 is active-set and 6 is active-clear. Bits [7:0] give the word (number/32), and bit (number mod 32) maps to the interrupt. Writing a 1 sets or clears that bit, and writing a 0 leaves it unchanged. A read of either view returns the current state, and enable and active change only by bus writes.
- R3: Group 7 word number/4 holds the 8-bit priority of each interrupt at byte number mod 4. A lower value wins, and on equal values the lower number wins.
- R4: In group 8, word number/4 byte number mod 4 is the routing byte of a shared interrupt. Bit n routes it to CPU n. Words 0-7 ignore writes, and every byte of those words reads as a one-hot mask of the reading CPU.
- R5: In group 9, word number/16 bit 2*(number mod 16)+1 selects rising-edge (1) or level-high (0) triggering. The even bits read 0. Word 0 reads 0xAAAAAAAA and ignores writes.
- R6: An edge-triggered input sets its pending bit on a 0-to-1 transition. The bit then holds until software clears it.
- R7: A level-triggered input forces its pending bit to 1 in every cycle that the input is high, so a clear does not stick. Once the input is low, the pending bit keeps its value.
- R8: A write to word 0x002 sets pending for software interrupt wdata[3:0] in the bank of every CPU n whose bit wdata[16+n] is set.
- R9: Word 0x001 reads NUM_IRQ/32-1 in bits [4:0]. Word 0x000 bit 0 is the global enable.
- R10: For each CPU, `cpu_irq_valid`/`cpu_irq_id` show the winner among interrupts that are pending, enabled and not active, and that are either numbered below 32 in that CPU's bank or routed to that CPU. Numbers at or above 1020 are never forwarded. The outputs follow the state one cycle later.
- R11: While the global enable is 0, no CPU output is valid.
- R12: `bus_rdata` is registered and holds the read result from the cycle after `bus_rd`. Unmapped words read 0.
- R13: After reset all state, priorities, routing, triggers and the global enable are 0, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cpu | input | CPU_W | Index of the CPU making the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| spi_in | input | NUM_IRQ-32 | Shared interrupt lines, bit k is number 32+k |
| ppi_in | input | 16*NUM_CPU | Private lines, bits [16c+15:16c] are numbers 16-31 of CPU c |
| cpu_irq_valid | output | NUM_CPU | Candidate present, per CPU |
| cpu_irq_id | output | ID_W*NUM_CPU | Winning interrupt number, per CPU |

## Verification
On every cycle the assertions check that the global enable gates all outputs and that a valid output follows a cycle with forwarding enabled. They also check that enable and active state change only on a bus write, and that a software-interrupt write lands in the pending bank of every listed CPU. The arbitration order, the banking seen from different CPUs, read-only routing words, edge-versus-level capture and masking by the active bit need a state set up over several writes. Only the bench scenarios can show those, by reading registers back and watching the outputs per CPU.

// File: rtl/intd_pkg.sv
package intd_pkg;

    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 32;
    localparam int CPU_IDX_W = 3;

    localparam logic [3:0] BK_MISC   = 4'd0;
    localparam logic [3:0] BK_EN_SET = 4'd1;
    localparam logic [3:0] BK_EN_CLR = 4'd2;
    localparam logic [3:0] BK_PD_SET = 4'd3;
    localparam logic [3:0] BK_PD_CLR = 4'd4;
    localparam logic [3:0] BK_AC_SET = 4'd5;
    localparam logic [3:0] BK_AC_CLR = 4'd6;
    localparam logic [3:0] BK_PRIO   = 4'd7;
    localparam logic [3:0] BK_TGT    = 4'd8;
    localparam logic [3:0] BK_CFG    = 4'd9;

    localparam logic [7:0] MISC_CTRL = 8'd0;
    localparam logic [7:0] MISC_TYPE = 8'd1;
    localparam logic [7:0] MISC_SGI  = 8'd2;

    typedef enum logic [1:0] {
        ST_EN   = 2'd0,
        ST_PEND = 2'd1,
        ST_ACT  = 2'd2
    } state_sel_e;

    typedef struct packed {
        logic                 wr;
        logic                 set;
        state_sel_e           sel;
        logic [7:0]           word;
        logic [DATA_W-1:0]    mask;
        logic [CPU_IDX_W-1:0] cpu;
    } st_req_t;

    function automatic logic [DATA_W-1:0] cpu_mask_rep(input logic [CPU_IDX_W-1:0] cpu);
        logic [7:0] one;
        one = 8'd1 << cpu;
        return {4{one}};
    endfunction

endpackage

// File: rtl/intd_capture.sv
module intd_capture
    import intd_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 4,
    localparam int NUM_SPI = NUM_IRQ - 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_CPU-1:0][15:0]  ppi_in,
    input  logic [NUM_SPI-1:0]        spi_in,
    input  logic [NUM_IRQ-1:16]       cfg_edge,
    output logic [NUM_CPU-1:0][15:0]  ppi_hit,
    output logic [NUM_SPI-1:0]        spi_hit
);

    logic [NUM_CPU-1:0][15:0] ppi_prev;
    logic [NUM_SPI-1:0]       spi_prev;
    logic [15:0]              ppi_edge;
    logic [NUM_SPI-1:0]       spi_edge;

    assign ppi_edge = cfg_edge[31:16];
    assign spi_edge = cfg_edge[NUM_IRQ-1:32];

    always_ff @(posedge clk) begin
        if (rst) begin
            ppi_prev <= '0;
            spi_prev <= '0;
        end else begin
            ppi_prev <= ppi_in;
            spi_prev <= spi_in;
        end
    end

    // edge: rising transition only; level: every cycle the line is high
    assign spi_hit = (spi_in & ~spi_prev & spi_edge) | (spi_in & ~spi_edge);

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_ppi
        assign ppi_hit[c] = (ppi_in[c] & ~ppi_prev[c] & ppi_edge) | (ppi_in[c] & ~ppi_edge);
    end

endmodule

// File: rtl/intd_state.sv
module intd_state
    import intd_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 4,
    localparam int NUM_SPI   = NUM_IRQ - 32,
    localparam int NUM_WORDS = NUM_IRQ / 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  st_req_t                   req,
    input  logic                      sgi_wr,
    input  logic [NUM_CPU-1:0]        sgi_tgt,
    input  logic [3:0]                sgi_id,
    input  logic [NUM_CPU-1:0][15:0]  ppi_hit,
    input  logic [NUM_SPI-1:0]        spi_hit,
    output logic [NUM_CPU-1:0][31:0]  priv_en,
    output logic [NUM_CPU-1:0][31:0]  priv_pend,
    output logic [NUM_CPU-1:0][31:0]  priv_act,
    output logic [NUM_SPI-1:0]        spi_en,
    output logic [NUM_SPI-1:0]        spi_pend,
    output logic [NUM_SPI-1:0]        spi_act
);

    // index 0: enable, 1: pending, 2: active
    logic [2:0][NUM_CPU-1:0][31:0] p_set, p_clr;
    logic [2:0][NUM_SPI-1:0]       s_set, s_clr;

    always_comb begin
        p_set = '0;
        p_clr = '0;
        s_set = '0;
        s_clr = '0;
        if (req.wr && (int'(req.word) < NUM_WORDS)) begin
            if (req.word == 8'd0) begin
                for (int c = 0; c < NUM_CPU; c++) begin
                    if (int'(req.cpu) == c) begin
                        if (req.set) p_set[req.sel][c] = req.mask;
                        else         p_clr[req.sel][c] = req.mask;
                    end
                end
            end else begin
                for (int w = 1; w < NUM_WORDS; w++) begin
                    if (int'(req.word) == w) begin
                        if (req.set) s_set[req.sel][(w-1)*32 +: 32] = req.mask;
                        else         s_clr[req.sel][(w-1)*32 +: 32] = req.mask;
                    end
                end
            end
        end
        for (int c = 0; c < NUM_CPU; c++) begin
            p_set[ST_PEND][c][31:16] = p_set[ST_PEND][c][31:16] | ppi_hit[c];
            if (sgi_wr && sgi_tgt[c]) p_set[ST_PEND][c][sgi_id] = 1'b1;
        end
        s_set[ST_PEND] = s_set[ST_PEND] | spi_hit;
    end

    // hardware and software sets win over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            priv_en   <= '0;
            priv_pend <= '0;
            priv_act  <= '0;
            spi_en    <= '0;
            spi_pend  <= '0;
            spi_act   <= '0;
        end else begin
            priv_en   <= (priv_en   & ~p_clr[ST_EN])   | p_set[ST_EN];
            priv_pend <= (priv_pend & ~p_clr[ST_PEND]) | p_set[ST_PEND];
            priv_act  <= (priv_act  & ~p_clr[ST_ACT])  | p_set[ST_ACT];
            spi_en    <= (spi_en    & ~s_clr[ST_EN])   | s_set[ST_EN];
            spi_pend  <= (spi_pend  & ~s_clr[ST_PEND]) | s_set[ST_PEND];
            spi_act   <= (spi_act   & ~s_clr[ST_ACT])  | s_set[ST_ACT];
        end
    end

    // R2
    en_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req.wr |=> ($stable(spi_en) && $stable(priv_en)));

    // R2
    act_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req.wr |=> ($stable(spi_act) && $stable(priv_act)));

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_sgi_chk
        // R8
        sgi_pend_chk: assert property (@(posedge clk) disable iff (rst)
            (sgi_wr && sgi_tgt[c]) |=> priv_pend[c][$past(sgi_id)]);
    end

endmodule

// File: rtl/intd_arbiter.sv
module intd_arbiter #(
    parameter int NUM_IRQ  = 64,
    parameter int NUM_LIVE = 64,
    parameter int ID_W     = 6
) (
    input  logic [NUM_IRQ-1:0]       cand,
    input  logic [NUM_IRQ-1:0][7:0]  prio,
    output logic                     hit,
    output logic [ID_W-1:0]          id
);

    logic [8:0] best;

    // ascending scan with strict compare keeps the lower number on ties
    always_comb begin
        best = 9'h100;
        hit  = 1'b0;
        id   = '0;
        for (int i = 0; i < NUM_LIVE; i++) begin
            if (cand[i] && ({1'b0, prio[i]} < best)) begin
                best = {1'b0, prio[i]};
                hit  = 1'b1;
                id   = ID_W'(i);
            end
        end
    end

endmodule

// File: rtl/intd_dist.sv
module intd_dist
    import intd_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 4,
    localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int ID_W    = $clog2(NUM_IRQ),
    localparam int NUM_SPI = NUM_IRQ - 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [CPU_W-1:0]          bus_cpu,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic [NUM_SPI-1:0]        spi_in,
    input  logic [16*NUM_CPU-1:0]     ppi_in,
    output logic [NUM_CPU-1:0]        cpu_irq_valid,
    output logic [ID_W*NUM_CPU-1:0]   cpu_irq_id
);

    localparam int NUM_WORDS = NUM_IRQ / 32;
    localparam int NUM_LIVE  = (NUM_IRQ > 1020) ? 1020 : NUM_IRQ;

    logic [3:0]            bank;
    logic [7:0]            idx;
    logic [CPU_IDX_W-1:0]  cpu_x;

    assign bank  = bus_addr[11:8];
    assign idx   = bus_addr[7:0];
    assign cpu_x = CPU_IDX_W'(bus_cpu);

    logic                           glob_en;
    logic [NUM_IRQ-1:0][7:0]        prio_q;
    logic [NUM_SPI-1:0][NUM_CPU-1:0] tgt_q;
    logic [NUM_IRQ-1:16]            edge_q;

    logic [NUM_CPU-1:0][31:0] priv_en, priv_pend, priv_act;
    logic [NUM_SPI-1:0]       spi_en, spi_pend, spi_act;
    logic [NUM_CPU-1:0][15:0] ppi_v, ppi_hit;
    logic [NUM_SPI-1:0]       spi_hit;

    st_req_t              st_req;
    logic                 sgi_wr;

    assign ppi_v = ppi_in;

    // ---------------- state access decode ----------------
    always_comb begin
        st_req      = '0;
        st_req.word = idx;
        st_req.mask = bus_wdata;
        st_req.cpu  = cpu_x;
        st_req.set  = bank[0];
        unique case (bank)
            BK_EN_SET, BK_EN_CLR: begin st_req.wr = bus_wr; st_req.sel = ST_EN;   end
            BK_PD_SET, BK_PD_CLR: begin st_req.wr = bus_wr; st_req.sel = ST_PEND; end
            BK_AC_SET, BK_AC_CLR: begin st_req.wr = bus_wr; st_req.sel = ST_ACT;  end
            default:              begin st_req.wr = 1'b0;   st_req.sel = ST_EN;   end
        endcase
    end

    assign sgi_wr = bus_wr && (bank == BK_MISC) && (idx == MISC_SGI);

    // ---------------- configuration registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            glob_en <= 1'b0;
            prio_q  <= '0;
            tgt_q   <= '0;
            edge_q  <= '0;
        end else if (bus_wr) begin
            if (bank == BK_MISC && idx == MISC_CTRL) glob_en <= bus_wdata[0];
            if (bank == BK_PRIO) begin
                for (int i = 0; i < NUM_IRQ; i++)
                    if ((i / 4) == int'(idx)) prio_q[i] <= bus_wdata[(i % 4)*8 +: 8];
            end
            if (bank == BK_TGT) begin
                for (int i = 32; i < NUM_IRQ; i++)
                    if ((i / 4) == int'(idx)) tgt_q[i-32] <= bus_wdata[(i % 4)*8 +: NUM_CPU];
            end
            if (bank == BK_CFG) begin
                for (int i = 16; i < NUM_IRQ; i++)
                    if ((i / 16) == int'(idx)) edge_q[i] <= bus_wdata[(i % 16)*2 + 1];
            end
        end
    end

    // ---------------- submodules ----------------
    intd_capture #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_capture (
        .clk      (clk),
        .rst      (rst),
        .ppi_in   (ppi_v),
        .spi_in   (spi_in),
        .cfg_edge (edge_q),
        .ppi_hit  (ppi_hit),
        .spi_hit  (spi_hit)
    );

    intd_state #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_state (
        .clk       (clk),
        .rst       (rst),
        .req       (st_req),
        .sgi_wr    (sgi_wr),
        .sgi_tgt   (bus_wdata[16 +: NUM_CPU]),
        .sgi_id    (bus_wdata[3:0]),
        .ppi_hit   (ppi_hit),
        .spi_hit   (spi_hit),
        .priv_en   (priv_en),
        .priv_pend (priv_pend),
        .priv_act  (priv_act),
        .spi_en    (spi_en),
        .spi_pend  (spi_pend),
        .spi_act   (spi_act)
    );

    // ---------------- read path ----------------
    logic [31:0] pv_en, pv_pd, pv_ac, sw_en, sw_pd, sw_ac, rd_val;

    always_comb begin
        pv_en = '0; pv_pd = '0; pv_ac = '0;
        sw_en = '0; sw_pd = '0; sw_ac = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (int'(cpu_x) == c) begin
                pv_en = priv_en[c];
                pv_pd = priv_pend[c];
                pv_ac = priv_act[c];
            end
        end
        for (int w = 1; w < NUM_WORDS; w++) begin
            if (int'(idx) == w) begin
                sw_en = spi_en[(w-1)*32 +: 32];
                sw_pd = spi_pend[(w-1)*32 +: 32];
                sw_ac = spi_act[(w-1)*32 +: 32];
            end
        end
    end

    always_comb begin
        rd_val = '0;
        case (bank)
            BK_MISC: begin
                if (idx == MISC_CTRL) rd_val = {31'd0, glob_en};
                if (idx == MISC_TYPE) rd_val = {27'd0, 5'(NUM_IRQ/32 - 1)};
            end
            BK_EN_SET, BK_EN_CLR: rd_val = (idx == 8'd0) ? pv_en : sw_en;
            BK_PD_SET, BK_PD_CLR: rd_val = (idx == 8'd0) ? pv_pd : sw_pd;
            BK_AC_SET, BK_AC_CLR: rd_val = (idx == 8'd0) ? pv_ac : sw_ac;
            BK_PRIO: begin
                for (int i = 0; i < NUM_IRQ; i++)
                    if ((i / 4) == int'(idx)) rd_val[(i % 4)*8 +: 8] = prio_q[i];
            end
            BK_TGT: begin
                if (idx < 8'd8) rd_val = cpu_mask_rep(cpu_x);
                else begin
                    for (int i = 32; i < NUM_IRQ; i++)
                        if ((i / 4) == int'(idx)) rd_val[(i % 4)*8 +: NUM_CPU] = tgt_q[i-32];
                end
            end
            BK_CFG: begin
                if (idx == 8'd0) rd_val = 32'hAAAA_AAAA;
                else begin
                    for (int i = 16; i < NUM_IRQ; i++)
                        if ((i / 16) == int'(idx)) rd_val[(i % 16)*2 + 1] = edge_q[i];
                end
            end
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
    end

    // ---------------- per-CPU selection ----------------
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic [NUM_IRQ-1:0] cand;
        logic               hit;
        logic [ID_W-1:0]    win_id;
        logic               valid_q;
        logic [ID_W-1:0]    id_q;

        always_comb begin
            cand       = '0;
            cand[31:0] = priv_en[c] & priv_pend[c] & ~priv_act[c];
            for (int i = 32; i < NUM_IRQ; i++)
                cand[i] = spi_en[i-32] & spi_pend[i-32] & ~spi_act[i-32] & tgt_q[i-32][c];
        end

        intd_arbiter #(.NUM_IRQ(NUM_IRQ), .NUM_LIVE(NUM_LIVE), .ID_W(ID_W)) u_arb (
            .cand (cand),
            .prio (prio_q),
            .hit  (hit),
            .id   (win_id)
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q <= 1'b0;
                id_q    <= '0;
            end else begin
                valid_q <= glob_en & hit;
                id_q    <= hit ? win_id : '0;
            end
        end

        assign cpu_irq_valid[c]            = valid_q;
        assign cpu_irq_id[c*ID_W +: ID_W]  = id_q;

        // R11
        fwd_src_chk: assert property (@(posedge clk) disable iff (rst)
            cpu_irq_valid[c] |-> $past(glob_en));
    end

    // R11
    gate_off_chk: assert property (@(posedge clk) disable iff (rst)
        !glob_en |=> (cpu_irq_valid == '0));

endmodule

// File: tb/intd_dist_tb_top.sv
`timescale 1ns/1ps
module intd_dist_tb_top;

    localparam int NUM_IRQ = 64;
    localparam int NUM_CPU = 4;
    localparam int CPU_W   = 2;
    localparam int ID_W    = 6;

    logic                    clk = 1'b0;
    logic                    rst;
    logic [CPU_W-1:0]        bus_cpu;
    logic                    bus_wr, bus_rd;
    logic [11:0]             bus_addr;
    logic [31:0]             bus_wdata, bus_rdata;
    logic [NUM_IRQ-33:0]     spi_in;
    logic [16*NUM_CPU-1:0]   ppi_in;
    logic [NUM_CPU-1:0]      cpu_irq_valid;
    logic [ID_W*NUM_CPU-1:0] cpu_irq_id;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen;

    always #2 clk = ~clk;

    intd_dist #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) dut_i (
        .clk(clk), .rst(rst), .bus_cpu(bus_cpu), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_in(spi_in), .ppi_in(ppi_in),
        .cpu_irq_valid(cpu_irq_valid), .cpu_irq_id(cpu_irq_id)
    );

    always @(posedge clk) rd_seen <= bus_rd;

    // monitor: compares returned read data against the scoreboard queue
    always @(negedge clk) begin
        if (rd_seen === 1'b1 && exp_q.size() > 0) begin
            logic [31:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                errors++;
                $display("FAIL %s: rdata got %h expected %h", t, bus_rdata, e);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int cpu, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_cpu = CPU_W'(cpu); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int cpu, input logic [11:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_cpu = CPU_W'(cpu); bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk_out(input int cpu, input logic v, input int id, input string t);
        logic [ID_W-1:0] got_id;
        got_id = cpu_irq_id[cpu*ID_W +: ID_W];
        checks++;
        if (cpu_irq_valid[cpu] !== v || (v && got_id !== ID_W'(id))) begin
            errors++;
            $display("FAIL %s: cpu%0d valid/id got %b/%0d expected %b/%0d",
                     t, cpu, cpu_irq_valid[cpu], got_id, v, id);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_cpu = '0; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_addr = '0; bus_wdata = '0; spi_in = '0; ppi_in = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R13 / R9 reset state and type word
        rd(0, 12'h000, 32'h0, "R13 ctrl reset");
        rd(0, 12'h001, 32'h1, "R9 type field");
        rd(0, 12'h101, 32'h0, "R13 enable reset");
        for (int c = 0; c < NUM_CPU; c++) chk_out(c, 1'b0, 0, "R13 outputs reset");

        // R2 set/clear views, zero writes
        wr(0, 12'h101, 32'h0000_0100);
        rd(0, 12'h101, 32'h0000_0100, "R2 enable set view");
        rd(0, 12'h201, 32'h0000_0100, "R2 enable clear view read");
        wr(0, 12'h201, 32'h0);
        wr(0, 12'h101, 32'h0);
        rd(0, 12'h101, 32'h0000_0100, "R2 zero write no effect");

        // R4 routing bytes and read-only private words
        wr(0, 12'h80A, 32'h0000_0002);
        rd(0, 12'h80A, 32'h0000_0002, "R4 routing readback");
        rd(2, 12'h800, 32'h0404_0404, "R4 private routing cpu2");
        wr(2, 12'h800, 32'hFFFF_FFFF);
        rd(2, 12'h800, 32'h0404_0404, "R4 private routing write ignored");
        rd(0, 12'h807, 32'h0101_0101, "R4 private routing cpu0");

        // R10 / R7 level forwarding of number 40 to cpu1
        wr(0, 12'h70A, 32'h0000_0080);
        wr(0, 12'h000, 32'h1);
        @(negedge clk); spi_in[8] = 1'b1;
        idle(3);
        chk_out(1, 1'b1, 40, "R10 level id40 to cpu1");
        chk_out(0, 1'b0, 0,  "R10 not routed to cpu0");

        // R7 clear does not stick while high, holds after drop
        wr(0, 12'h401, 32'h0000_0100);
        rd(0, 12'h301, 32'h0000_0100, "R7 level reasserts pending");
        @(negedge clk); spi_in[8] = 1'b0;
        idle(2);
        rd(0, 12'h301, 32'h0000_0100, "R7 pending held after drop");
        wr(0, 12'h401, 32'h0000_0100);
        rd(0, 12'h301, 32'h0, "R2 pending clear");
        idle(2);
        chk_out(1, 1'b0, 0, "R10 nothing pending");

        // R5 trigger configuration
        wr(0, 12'h903, 32'h0000_0020);
        rd(0, 12'h903, 32'h0000_0020, "R5 edge bit id50");
        wr(0, 12'h902, 32'hFFFF_FFFF);
        rd(0, 12'h902, 32'hAAAA_AAAA, "R5 only odd bits stored");
        wr(0, 12'h902, 32'h0);
        wr(0, 12'h900, 32'h0);
        rd(0, 12'h900, 32'hAAAA_AAAA, "R5 software word fixed");

        // R6 edge capture on number 50
        wr(0, 12'h101, 32'h0004_0100);
        wr(0, 12'h80C, 32'h0002_0000);
        wr(0, 12'h70C, 32'h0020_0000);
        @(negedge clk); spi_in[18] = 1'b1;
        @(negedge clk); spi_in[18] = 1'b0;
        idle(2);
        rd(0, 12'h301, 32'h0004_0000, "R6 edge latched pending");
        chk_out(1, 1'b1, 50, "R6 edge id50 forwarded");

        // R3 priority and tie-break
        @(negedge clk); spi_in[8] = 1'b1;
        idle(3);
        chk_out(1, 1'b1, 50, "R3 lower value wins (50)");
        wr(0, 12'h70A, 32'h0000_0010);
        idle(2);
        chk_out(1, 1'b1, 40, "R3 lower value wins (40)");
        wr(0, 12'h70A, 32'h0000_0020);
        idle(2);
        chk_out(1, 1'b1, 40, "R3 tie lower number");

        // R11 global gate
        wr(0, 12'h000, 32'h0);
        idle(2);
        chk_out(1, 1'b0, 0, "R11 gate off");
        wr(0, 12'h000, 32'h1);
        idle(2);
        chk_out(1, 1'b1, 40, "R11 gate on again");

        // R8 / R1 software interrupt to cpu0 and cpu2
        wr(1, 12'h002, 32'h0005_0003);
        rd(0, 12'h300, 32'h0000_0008, "R8 sgi pending cpu0");
        rd(1, 12'h300, 32'h0, "R1 sgi absent cpu1");
        rd(2, 12'h300, 32'h0000_0008, "R8 sgi pending cpu2");

        // R1 banked enable
        wr(2, 12'h100, 32'h0000_0008);
        rd(0, 12'h100, 32'h0, "R1 cpu0 enable bank untouched");
        idle(2);
        chk_out(2, 1'b1, 3, "R10 banked id3 cpu2");
        chk_out(0, 1'b0, 0, "R1 cpu0 not enabled");

        // R10 active masks forwarding
        wr(2, 12'h500, 32'h0000_0008);
        rd(2, 12'h500, 32'h0000_0008, "R2 active set view");
        idle(1);
        chk_out(2, 1'b0, 0, "R10 active excluded");
        wr(2, 12'h600, 32'h0000_0008);
        idle(2);
        chk_out(2, 1'b1, 3, "R10 active cleared");

        // R12 unmapped read
        rd(0, 12'hF00, 32'h0, "R12 unmapped reads zero");

        idle(3);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule